// File: doc/BRIEF.md
# Graphics Status Word and Draw-Mode Command Decoder

This block keeps the state behind a graphics unit's 32-bit status word. A command port takes one 32-bit word per cycle when `cmd_valid` is high. The top byte of the word is the opcode. Opcode 0xE1 sets the draw mode: it loads the texture page base, the semi-transparency mode and the texture colour depth. Any other opcode is refused. A refused command changes nothing and raises `cmd_unknown` for one cycle. A draw-mode word whose depth code is the illegal value 3 is also refused, and it raises `cmd_bad_depth` for one cycle.

The display configuration fields are loaded together through a separate write strobe. These are dithering, the mask controls, the field, texture disable, the resolutions, the video mode, the colour depth, interlace, display disable, the interrupt flag and the DMA direction. The status word is combinational from the stored fields.

A small state register records what the last cycle did. Its states are:
- `CS_IDLE`: no command was taken.
- `CS_LOADED`: a draw mode was applied.
- `CS_BAD_DEPTH`: a draw mode with the illegal depth was refused.
- `CS_UNKNOWN`: an unhandled opcode was refused.

Every cycle the next state is chosen from the inputs alone:
- `CS_IDLE` when `cmd_valid` is low.
- `CS_UNKNOWN` when the opcode is not 0xE1.
- `CS_BAD_DEPTH` when the opcode is 0xE1 and the depth code is 3.
- `CS_LOADED` otherwise.

Any state may move to any other. The two error outputs decode the current state.

Top module: `gpustat_top`

## Requirements
- R1: After reset `status` reads 0x1C800000. Every stored field is 0, except display disable (status bit 23), which is 1.
- R2: A valid word with opcode 0xE1 and bits 8:7 not equal to 3 updates the draw-mode fields in `status` from the next cycle on:
  - word bits 3:0 go to page X (status 3:0);
  - word bit 4 goes to page Y (status 4);
  - word bits 6:5 go to semi-transparency (status 6:5);
  - word bits 8:7 go to texture depth (status 8:7), with code 0 = 4-bit, 1 = 8-bit, 2 = 15-bit.
- R3: A valid 0xE1 word with bits 8:7 equal to 3 leaves every status bit unchanged. It drives `cmd_bad_depth` high for exactly the next cycle.
- R4: A valid word with any opcode other than 0xE1 leaves every status bit unchanged. It drives `cmd_unknown` high for exactly the next cycle.
- R5: `cfg_we` loads `cfg_data` from the next cycle on. The field positions are:

  | `cfg_data` bit(s) | Field | `status` bit(s) |
  |---|---|---|
  | 0 | dither | 9 |
  | 1 | draw-to-display | 10 |
  | 2 | force mask | 11 |
  | 3 | preserve masked | 12 |
  | 4 | field | 13 |
  | 5 | texture disable | 15 |
  | 9 | vertical resolution | 19 |
  | 10 | video mode | 20 |
  | 11 | display depth | 21 |
  | 12 | interlace | 22 |
  | 13 | display disable | 23 |
  | 14 | interrupt | 24 |
  | 16:15 | DMA direction | 30:29 |

- R6: The horizontal resolution in status bits 18:16 equals {`cfg_data`[7:6], `cfg_data`[8]}, with `cfg_data`[8] in bit 16.
- R7: Status bits 26, 27 and 28 always read 1. Bits 14 and 31 always read 0.
- R8: Status bit 25 (DMA request) depends on the direction field:
  - direction 0 gives 0;
  - direction 1 gives 1;
  - direction 2 gives a copy of bit 28;
  - direction 3 gives a copy of bit 27.
- R9: Command words on consecutive cycles are each processed. The last accepted draw mode wins.
- R10: A cycle with `cmd_valid` low produces no error pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 32 | Command word, opcode in bits 31:24 |
| cfg_we | input | 1 | Display configuration write strobe |
| cfg_data | input | 17 | Display configuration fields (layout in R5, R6) |
| status | output | 32 | Assembled status word |
| cmd_unknown | output | 1 | One-cycle pulse for an unhandled opcode |
| cmd_bad_depth | output | 1 | One-cycle pulse for an illegal texture depth |

## Verification
The hardest case to reach is a refused command that arrives immediately after an accepted one. The refusal must then leave the freshly loaded fields untouched while its error pulse shows up in the same cycle the previous state would have persisted. Random stimulus rarely lines this up, so directed back-to-back sequences cover it. These place an illegal-depth word and an unknown opcode right after a valid draw mode. A configuration write lands in the same cycle as a command. The random phase then draws opcode 0xE1 half of the time with all four depth codes, so all four states follow each other in every order.

// File: rtl/gpustat_pkg.sv
package gpustat_pkg;
    localparam int CMD_W   = 32;
    localparam int OPC_W   = 8;
    localparam int STAT_W  = 32;
    localparam int DRAW_W  = 9;
    localparam int CFG_W   = 17;
    localparam logic [OPC_W-1:0] OPC_DRAW_MODE = 8'hE1;

    typedef enum logic [1:0] {
        TEX_4BIT  = 2'd0,
        TEX_8BIT  = 2'd1,
        TEX_15BIT = 2'd2,
        TEX_BAD   = 2'd3
    } tex_depth_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_LOADED,
        CS_BAD_DEPTH,
        CS_UNKNOWN
    } cmd_state_e;

    typedef struct packed {
        tex_depth_e  depth;
        logic [1:0]  semi;
        logic        page_y;
        logic [3:0]  page_x;
    } draw_t;

    typedef struct packed {
        logic [1:0]  dma_dir;
        logic        irq;
        logic        disp_off;
        logic        interlace;
        logic        disp24;
        logic        vmode;
        logic        vres;
        logic        hr2;
        logic [1:0]  hr1;
        logic        tex_off;
        logic        field;
        logic        keep_masked;
        logic        force_mask;
        logic        draw_to_disp;
        logic        dither;
    } disp_cfg_t;
endpackage

// File: rtl/gpustat_cmd_dec.sv
module gpustat_cmd_dec
    import gpustat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output draw_t            draw,
    output logic             err_unknown,
    output logic             err_depth
);
    cmd_state_e state_q, state_d;
    draw_t      draw_q;
    draw_t      cand;
    logic       unused_mid;

    assign cand       = draw_t'(cmd_word[DRAW_W-1:0]);
    assign unused_mid = ^cmd_word[CMD_W-OPC_W-1:DRAW_W];

    always_comb begin
        if (!cmd_valid)
            state_d = CS_IDLE;
        else if (cmd_word[CMD_W-1 -: OPC_W] != OPC_DRAW_MODE)
            state_d = CS_UNKNOWN;
        else if (cand.depth == TEX_BAD)
            state_d = CS_BAD_DEPTH;
        else
            state_d = CS_LOADED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            draw_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == CS_LOADED)
                draw_q <= cand;
        end
    end

    always_comb begin
        err_unknown = 1'b0;
        err_depth   = 1'b0;
        unique case (state_q)
            CS_IDLE:      ;
            CS_LOADED:    ;
            CS_BAD_DEPTH: err_depth   = 1'b1;
            CS_UNKNOWN:   err_unknown = 1'b1;
        endcase
    end

    assign draw = draw_q;
endmodule

// File: rtl/gpustat_disp_cfg.sv
module gpustat_disp_cfg
    import gpustat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] data,
    output disp_cfg_t        cfg
);
    localparam disp_cfg_t CFG_RESET = '{disp_off: 1'b1, default: '0};

    disp_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (we)
            cfg_q <= disp_cfg_t'(data);
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpustat_word.sv
module gpustat_word
    import gpustat_pkg::*;
(
    input  draw_t              draw,
    input  disp_cfg_t          cfg,
    output logic [STAT_W-1:0]  word
);
    logic [STAT_W-1:0] base;
    logic              dma_req;

    always_comb begin
        base        = '0;
        base[3:0]   = draw.page_x;
        base[4]     = draw.page_y;
        base[6:5]   = draw.semi;
        base[8:7]   = draw.depth;
        base[9]     = cfg.dither;
        base[10]    = cfg.draw_to_disp;
        base[11]    = cfg.force_mask;
        base[12]    = cfg.keep_masked;
        base[13]    = cfg.field;
        base[15]    = cfg.tex_off;
        base[18:16] = {cfg.hr1, cfg.hr2};
        base[19]    = cfg.vres;
        base[20]    = cfg.vmode;
        base[21]    = cfg.disp24;
        base[22]    = cfg.interlace;
        base[23]    = cfg.disp_off;
        base[24]    = cfg.irq;
        base[28:26] = 3'b111;
        base[30:29] = cfg.dma_dir;
    end

    always_comb begin
        unique case (cfg.dma_dir)
            2'd0: dma_req = 1'b0;
            2'd1: dma_req = 1'b1;
            2'd2: dma_req = base[28];
            2'd3: dma_req = base[27];
        endcase
    end

    always_comb begin
        word     = base;
        word[25] = dma_req;
    end
endmodule

// File: rtl/gpustat_top.sv
module gpustat_top
    import gpustat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic [STAT_W-1:0] status,
    output logic              cmd_unknown,
    output logic              cmd_bad_depth
);
    draw_t     draw;
    disp_cfg_t cfg;

    gpustat_cmd_dec u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .draw        (draw),
        .err_unknown (cmd_unknown),
        .err_depth   (cmd_bad_depth)
    );

    gpustat_disp_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .data  (cfg_data),
        .cfg   (cfg)
    );

    gpustat_word u_word (
        .draw (draw),
        .cfg  (cfg),
        .word (status)
    );
endmodule

// File: rtl/gpustat_chk.sv
module gpustat_chk
    import gpustat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [CMD_W-1:0]  cmd_word,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_data,
    input logic [STAT_W-1:0] status,
    input logic              cmd_unknown,
    input logic              cmd_bad_depth
);
    logic is_draw;
    assign is_draw = cmd_valid && (cmd_word[31:24] == OPC_DRAW_MODE);

    // R2
    draw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_draw && (cmd_word[8:7] != 2'd3) |=> status[8:0] == $past(cmd_word[8:0]));

    // R3
    bad_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_draw && (cmd_word[8:7] == 2'd3) |=> cmd_bad_depth && $stable(status[8:0]));

    // R4
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !is_draw |=> cmd_unknown && $stable(status[8:0]));

    // R7
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[28:26] == 3'b111 && !status[14] && !status[31]);

    // R8
    dma_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[25] == ((status[30:29] == 2'd1) ||
                       (status[30:29] == 2'd2 && status[28]) ||
                       (status[30:29] == 2'd3 && status[27])));

    // R6
    hres_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> status[18:16] == {$past(cfg_data[7:6]), $past(cfg_data[8])});

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_unknown && !cmd_bad_depth);
endmodule

bind gpustat_top gpustat_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_word      (cmd_word),
    .cfg_we        (cfg_we),
    .cfg_data      (cfg_data),
    .status        (status),
    .cmd_unknown   (cmd_unknown),
    .cmd_bad_depth (cmd_bad_depth)
);

// File: tb/gpustat_top_tb.sv
module gpustat_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cfg_we = 1'b0;
    logic [16:0] cfg_data = '0;
    logic [31:0] status;
    logic        cmd_unknown;
    logic        cmd_bad_depth;

    int checks = 0;
    int errors = 0;

    logic [8:0]  m_draw;
    logic [16:0] m_cfg;
    logic        m_unk;
    logic        m_bad;

    always #4 clk = ~clk;

    gpustat_top u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cfg_we(cfg_we), .cfg_data(cfg_data), .status(status),
        .cmd_unknown(cmd_unknown), .cmd_bad_depth(cmd_bad_depth)
    );

    function automatic logic [31:0] exp_status(input logic [8:0] d, input logic [16:0] c);
        logic [31:0] s;
        s = '0;
        s[8:0]   = d;
        s[13:9]  = c[4:0];
        s[15]    = c[5];
        s[18:16] = {c[7:6], c[8]};
        s[24:19] = c[14:9];
        s[28:26] = 3'b111;
        s[30:29] = c[16:15];
        s[25]    = (c[16:15] != 2'd0);
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic we,
                        input logic [16:0] c, input string req);
        cmd_valid = v; cmd_word = w; cfg_we = we; cfg_data = c;
        m_unk = v && (w[31:24] != 8'hE1);
        m_bad = v && (w[31:24] == 8'hE1) && (w[8:7] == 2'd3);
        if (v && !m_unk && !m_bad) m_draw = w[8:0];
        if (we) m_cfg = c;
        @(negedge clk);
        check({req, " status"}, status, exp_status(m_draw, m_cfg));
        check({req, " unknown"}, {31'd0, cmd_unknown}, {31'd0, m_unk});
        check({req, " bad_depth"}, {31'd0, cmd_bad_depth}, {31'd0, m_bad});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_draw = '0; m_cfg = 17'h02000; m_unk = 1'b0; m_bad = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", status, 32'h1C80_0000);
        check("R1 reset errs", {30'd0, cmd_unknown, cmd_bad_depth}, 32'd0);
        step(1'b1, 32'hE100_015A, 1'b0, '0, "R2");
        step(1'b1, 32'hE100_0185, 1'b0, '0, "R3");
        step(1'b1, 32'hE200_0011, 1'b0, '0, "R4");
        step(1'b1, 32'h0000_0000, 1'b0, '0, "R4");
        step(1'b0, 32'hE100_0003, 1'b0, '0, "R10");
        step(1'b0, '0, 1'b1, 17'h0_3E3F, "R5");
        step(1'b0, '0, 1'b1, 17'h0_0140, "R6");
        for (int dir = 0; dir < 4; dir++)
            step(1'b0, '0, 1'b1, {dir[1:0], 15'h0123}, "R8");
        step(1'b1, 32'hE100_0021, 1'b0, '0, "R9");
        step(1'b1, 32'hE100_01FF, 1'b1, 17'h1_2000, "R9");
        step(1'b1, 32'hE100_0107, 1'b0, '0, "R9");
        step(1'b1, 32'h3100_0001, 1'b0, '0, "R9");
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(1, 0) == 1) w[31:24] = 8'hE1;
            step(1'($urandom_range(3, 0) != 0), w, 1'($urandom_range(3, 0) == 0),
                 17'($urandom), "R7");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule